// File: doc/BRIEF.md
# Paged NIC Control Register File

This block is the byte-wide host register bank of a ring-buffer Ethernet controller. The host sees sixteen offsets on a 4-bit address. Offset 0 is always the command register, and its top two bits choose which page the other fifteen offsets decode to. A given offset can mean one register when written and a different one when read. The bank holds the receive ring page pointers, the transmit page and length, the remote DMA address and count, the receive and data configuration bytes, the station address and the multicast hash bytes. It also holds the interrupt status and mask registers and drives the interrupt line.

A write to the command register can start a transmission. The block then issues a one-cycle request that carries the transmit page and byte count, and it records completion in its status. The MAC, the packet memory and the DMA engine live elsewhere. They read the configuration outputs, and they report their events through a per-bit set input on the status register.

Top module: `nic_regbank`

## Requirements
- R1: Reset leaves the command register at 0x01 (stop bit set, page 0), the status register at 0x80, the mask at zero and every other register at zero. The interrupt and transmit request outputs are low.
- R2: Offset 0 reads and writes the command register on every page. Bits 7:6 of the command register select the page. Any other offset reaches the register whose index is {page, offset}, so the same offset reaches different registers on different pages.
- R3: Reads decode as follows. Page 0 gives: offset 3 the boundary, 4 the transmit status, 7 the status register, 8 and 9 the remote address low and high bytes, 0x0A the constant 0x50, 0x0B the constant 0x43, and 0x0C the `rx_stat` input. Page 1 gives: offsets 1-6 the station bytes, 7 the current page, and 8-15 the hash bytes. Page 2 gives: offset 1 the ring start and 2 the ring stop. Every other read returns 0, and that includes all of page 3.
- R4: Writes decode as follows. Page 0 takes: 1 ring start, 2 ring stop, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 8/9 remote address low/high, 0x0A/0x0B remote count low/high, 0x0C receive config, 0x0E data config, and 0x0F mask. Page 1 takes: 1-6 station bytes 0-5, 7 current page, and 8-15 hash bytes 0-7. Station byte k sits at bits 8k+7:8k of `stn_addr`, and the same layout holds for `mc_hash`.
- R5: Each 16-bit register (transmit count, remote address, remote count) is written as two bytes. A write to one byte leaves the other byte unchanged.
- R6: A write to the status register (page 0, offset 7) clears each of bits 6:0 that is written as 1. Bit 7 is never cleared this way.
- R7: A bit set in `ev_set[6:0]` sets the status bit of the same position in the next cycle. A set in the same cycle as a clear of that bit wins.
- R8: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero. It follows the registers combinationally.
- R9: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves it unchanged.
- R10: A command write with stop clear and either bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 when the remote count is zero. It does not set bit 6 when the count is nonzero.
- R11: A command write with stop clear and bit 2 (transmit) set raises `tx_req` for the next cycle only. `tx_page` and `tx_len` then carry the transmit page and count. The write also sets status bit 1, sets the transmit status to 0x01, and stores the command with bit 2 cleared. With stop set, no request is made and the command is stored as written.
- R12: A ring start or ring stop write is ignored when its value exceeds END_PAGE (default 0x80). A boundary or current-page write is ignored when its value is END_PAGE or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` on the current page |
| ev_set | input | 7 | Event pulses that set status bits 6:0 |
| rx_stat | input | 8 | Receive status byte from the MAC, readable by the host |
| irq | output | 1 | Interrupt request |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page, valid with `tx_req` |
| tx_len | output | 16 | Transmit byte count, valid with `tx_req` |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| ring_bnd | output | 8 | Receive ring boundary page |
| ring_cur | output | 8 | Receive ring current page |
| rdma_addr | output | 16 | Remote DMA address |
| rdma_cnt | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |
| stn_addr | output | 48 | Station address, byte k at bits 8k+7:8k |
| mc_hash | output | 64 | Multicast hash bytes, byte k at bits 8k+7:8k |

## Verification
The assertions check several properties on every cycle:
- The transmit request lasts one cycle, carries the page and count held at the command write, and self-clears the transmit bit.
- A started command write always clears the reset status bit.
- Clearing by writing ones leaves no written bit set when no event arrives in the same cycle.
- A start-page write above the limit never moves the stored value.
- The interrupt is never raised while the mask is zero in bits 6:0.

Other behaviour shows only in the bench scenarios. This covers the page-dependent aliasing of one offset, the read-only constants, the half-register updates, the zero-count DMA completion, set-over-clear priority and bit 7 surviving a clear. The bench model is compared with the outputs and the read data on every clock.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  localparam int OFF_W = 4;
  localparam int PAGE_W = 2;
  localparam int IDX_W = OFF_W + PAGE_W;

  // command register bit positions
  localparam int CMD_STOP  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_XMIT  = 2;
  localparam int CMD_RRD   = 3;
  localparam int CMD_RWR   = 4;
  localparam int CMD_NODMA = 5;

  // status register bit positions
  localparam int ST_TXOK = 1;
  localparam int ST_RDC  = 6;
  localparam int ST_RST  = 7;

  localparam logic [7:0] CMD_RESET_VAL = 8'h01;
  localparam logic [7:0] ST_RESET_VAL  = 8'h80;
  localparam logic [7:0] ST_LIVE_MASK  = 8'h7F;
  localparam logic [7:0] TSR_DONE      = 8'h01;

  // effective register indices, {page, offset}
  localparam logic [IDX_W-1:0] IX_PSTART = 6'h01;
  localparam logic [IDX_W-1:0] IX_PSTOP  = 6'h02;
  localparam logic [IDX_W-1:0] IX_BND    = 6'h03;
  localparam logic [IDX_W-1:0] IX_TXPG   = 6'h04;
  localparam logic [IDX_W-1:0] IX_TCL    = 6'h05;
  localparam logic [IDX_W-1:0] IX_TCH    = 6'h06;
  localparam logic [IDX_W-1:0] IX_ST     = 6'h07;
  localparam logic [IDX_W-1:0] IX_RAL    = 6'h08;
  localparam logic [IDX_W-1:0] IX_RAH    = 6'h09;
  localparam logic [IDX_W-1:0] IX_RCL    = 6'h0A;
  localparam logic [IDX_W-1:0] IX_RCH    = 6'h0B;
  localparam logic [IDX_W-1:0] IX_RXC    = 6'h0C;
  localparam logic [IDX_W-1:0] IX_DCF    = 6'h0E;
  localparam logic [IDX_W-1:0] IX_MSK    = 6'h0F;
  localparam logic [IDX_W-1:0] IX_STN0   = 6'h11;
  localparam logic [IDX_W-1:0] IX_CUR    = 6'h17;
  localparam logic [IDX_W-1:0] IX_MC0    = 6'h18;
  localparam logic [IDX_W-1:0] IX_RSTART = 6'h21;
  localparam logic [IDX_W-1:0] IX_RSTOP  = 6'h22;

  function automatic logic [IDX_W-1:0] reg_index(input logic [PAGE_W-1:0] page,
                                                  input logic [OFF_W-1:0] off);
    return {page, off};
  endfunction

  // range test for page-pointer writes; allow_end accepts the limit itself
  function automatic logic page_fits(input logic [7:0] pg, input logic [7:0] end_pg,
                                     input logic allow_end);
    return allow_end ? (pg <= end_pg) : (pg < end_pg);
  endfunction

  function automatic logic [15:0] set_half(input logic [15:0] cur, input logic hi,
                                           input logic [7:0] b);
    return hi ? {b, cur[7:0]} : {cur[15:8], b};
  endfunction

  function automatic logic [7:0] next_status(input logic [7:0] cur, input logic [7:0] clr,
                                             input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
  import nic_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  wdata,
  input  logic [15:0] rcnt,
  input  logic [7:0]  tpsr,
  input  logic [15:0] tcnt,
  output logic [7:0]  cmd,
  output logic [7:0]  tsr,
  output logic        tx_req,
  output logic [7:0]  tx_page,
  output logic [15:0] tx_len,
  output logic        run_wr,
  output logic        rdc_hit,
  output logic        tx_fire
);

  logic [7:0] cmd_stored;

  assign run_wr  = cmd_wr && !wdata[CMD_STOP];
  assign rdc_hit = run_wr && (wdata[CMD_RRD] || wdata[CMD_RWR]) && (rcnt == 16'd0);
  assign tx_fire = run_wr && wdata[CMD_XMIT];

  always_comb begin
    cmd_stored = wdata;
    if (tx_fire) cmd_stored[CMD_XMIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= CMD_RESET_VAL;
      tsr     <= 8'h00;
      tx_req  <= 1'b0;
      tx_page <= 8'h00;
      tx_len  <= 16'h0000;
    end else begin
      tx_req <= tx_fire;
      if (cmd_wr) cmd <= cmd_stored;
      if (tx_fire) begin
        tx_page <= tpsr;
        tx_len  <= tcnt;
        tsr     <= TSR_DONE;
      end
    end
  end

endmodule

// File: rtl/nic_status_unit.sv
module nic_status_unit
  import nic_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic       msk_wr,
  input  logic [7:0] wdata,
  input  logic [6:0] ev_set,
  input  logic       run_wr,
  input  logic       rdc_hit,
  input  logic       tx_fire,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);

  logic [7:0] clr_bits;
  logic [7:0] set_bits;

  always_comb begin
    clr_bits = st_wr ? (wdata & ST_LIVE_MASK) : 8'h00;
    if (run_wr) clr_bits[ST_RST] = 1'b1;
    set_bits = {1'b0, ev_set};
    if (rdc_hit) set_bits[ST_RDC] = 1'b1;
    if (tx_fire) set_bits[ST_TXOK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= ST_RESET_VAL;
      mask   <= 8'h00;
    end else begin
      status <= next_status(status, clr_bits, set_bits);
      if (msk_wr) mask <= wdata;
    end
  end

  assign irq = |(status & mask & ST_LIVE_MASK);

endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_regbank_pkg::*;
#(
  parameter logic [7:0] END_PAGE = 8'h80,
  parameter int STN_BYTES  = 6,
  parameter int HASH_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              ring_start,
  output logic [7:0]              ring_stop,
  output logic [7:0]              ring_bnd,
  output logic [7:0]              ring_cur,
  output logic [7:0]              tpsr,
  output logic [15:0]             tcnt,
  output logic [15:0]             rdma_addr,
  output logic [15:0]             rdma_cnt,
  output logic [7:0]              rx_cfg,
  output logic [7:0]              data_cfg,
  output logic [8*STN_BYTES-1:0]  stn_addr,
  output logic [8*HASH_BYTES-1:0] mc_hash
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_start <= 8'h00;
      ring_stop  <= 8'h00;
      ring_bnd   <= 8'h00;
      ring_cur   <= 8'h00;
      tpsr       <= 8'h00;
      tcnt       <= 16'h0000;
      rdma_addr  <= 16'h0000;
      rdma_cnt   <= 16'h0000;
      rx_cfg     <= 8'h00;
      data_cfg   <= 8'h00;
    end else if (wr) begin
      unique case (idx)
        IX_PSTART: if (page_fits(wdata, END_PAGE, 1'b1)) ring_start <= wdata;
        IX_PSTOP:  if (page_fits(wdata, END_PAGE, 1'b1)) ring_stop  <= wdata;
        IX_BND:    if (page_fits(wdata, END_PAGE, 1'b0)) ring_bnd   <= wdata;
        IX_CUR:    if (page_fits(wdata, END_PAGE, 1'b0)) ring_cur   <= wdata;
        IX_TXPG:   tpsr      <= wdata;
        IX_TCL:    tcnt      <= set_half(tcnt, 1'b0, wdata);
        IX_TCH:    tcnt      <= set_half(tcnt, 1'b1, wdata);
        IX_RAL:    rdma_addr <= set_half(rdma_addr, 1'b0, wdata);
        IX_RAH:    rdma_addr <= set_half(rdma_addr, 1'b1, wdata);
        IX_RCL:    rdma_cnt  <= set_half(rdma_cnt, 1'b0, wdata);
        IX_RCH:    rdma_cnt  <= set_half(rdma_cnt, 1'b1, wdata);
        IX_RXC:    rx_cfg    <= wdata;
        IX_DCF:    data_cfg  <= wdata;
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < STN_BYTES; g++) begin : g_stn
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= 8'h00;
        else if (wr && idx == IX_STN0 + IDX_W'(g)) byte_q <= wdata;
      end
      assign stn_addr[8*g +: 8] = byte_q;
    end
    for (g = 0; g < HASH_BYTES; g++) begin : g_hash
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= 8'h00;
        else if (wr && idx == IX_MC0 + IDX_W'(g)) byte_q <= wdata;
      end
      assign mc_hash[8*g +: 8] = byte_q;
    end
  endgenerate

endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
  import nic_regbank_pkg::*;
#(
  parameter int STN_BYTES  = 6,
  parameter int HASH_BYTES = 8,
  parameter logic [7:0] ID_LO = 8'h50,
  parameter logic [7:0] ID_HI = 8'h43
) (
  input  logic [OFF_W-1:0]        off,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              cmd,
  input  logic [7:0]              status,
  input  logic [7:0]              tsr,
  input  logic [7:0]              rx_stat,
  input  logic [7:0]              ring_start,
  input  logic [7:0]              ring_stop,
  input  logic [7:0]              ring_bnd,
  input  logic [7:0]              ring_cur,
  input  logic [15:0]             rdma_addr,
  input  logic [8*STN_BYTES-1:0]  stn_addr,
  input  logic [8*HASH_BYTES-1:0] mc_hash,
  output logic [7:0]              rdata
);

  always_comb begin
    rdata = 8'h00;
    if (off == '0) begin
      rdata = cmd;
    end else begin
      unique case (idx)
        IX_BND:         rdata = ring_bnd;
        IX_TXPG:        rdata = tsr;
        IX_ST:          rdata = status;
        IX_RAL:         rdata = rdma_addr[7:0];
        IX_RAH:         rdata = rdma_addr[15:8];
        IX_RCL:         rdata = ID_LO;
        IX_RCH:         rdata = ID_HI;
        IX_RXC:         rdata = rx_stat;
        IX_CUR:         rdata = ring_cur;
        IX_RSTART:      rdata = ring_start;
        IX_RSTOP:       rdata = ring_stop;
        default: begin
          for (int k = 0; k < STN_BYTES; k++)
            if (idx == IX_STN0 + IDX_W'(k)) rdata = stn_addr[8*k +: 8];
          for (int k = 0; k < HASH_BYTES; k++)
            if (idx == IX_MC0 + IDX_W'(k)) rdata = mc_hash[8*k +: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter logic [7:0] END_PAGE = 8'h80,
  parameter int STN_BYTES  = 6,
  parameter int HASH_BYTES = 8,
  parameter logic [7:0] ID_LO = 8'h50,
  parameter logic [7:0] ID_HI = 8'h43
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic [3:0]              host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  input  logic [6:0]              ev_set,
  input  logic [7:0]              rx_stat,
  output logic                    irq,
  output logic                    tx_req,
  output logic [7:0]              tx_page,
  output logic [15:0]             tx_len,
  output logic [7:0]              ring_start,
  output logic [7:0]              ring_stop,
  output logic [7:0]              ring_bnd,
  output logic [7:0]              ring_cur,
  output logic [15:0]             rdma_addr,
  output logic [15:0]             rdma_cnt,
  output logic [7:0]              rx_cfg,
  output logic [7:0]              data_cfg,
  output logic [8*STN_BYTES-1:0]  stn_addr,
  output logic [8*HASH_BYTES-1:0] mc_hash
);

  // internal events and state, named for the checker
  logic [7:0]       cmd_v;
  logic [7:0]       isr_v;
  logic [7:0]       imr_v;
  logic [7:0]       tsr_v;
  logic [7:0]       tpsr_v;
  logic [15:0]      tcnt_v;
  logic [IDX_W-1:0] idx_v;
  logic             cmd_wr_v;
  logic             reg_wr_v;
  logic             run_wr_v;
  logic             rdc_hit_v;
  logic             tx_fire_v;

  assign idx_v    = reg_index(cmd_v[7:6], host_addr);
  assign cmd_wr_v = host_wr && (host_addr == '0);
  assign reg_wr_v = host_wr && (host_addr != '0);

  nic_cmd_unit u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr_v),
    .wdata   (host_wdata),
    .rcnt    (rdma_cnt),
    .tpsr    (tpsr_v),
    .tcnt    (tcnt_v),
    .cmd     (cmd_v),
    .tsr     (tsr_v),
    .tx_req  (tx_req),
    .tx_page (tx_page),
    .tx_len  (tx_len),
    .run_wr  (run_wr_v),
    .rdc_hit (rdc_hit_v),
    .tx_fire (tx_fire_v)
  );

  nic_status_unit u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_wr   (reg_wr_v && idx_v == IX_ST),
    .msk_wr  (reg_wr_v && idx_v == IX_MSK),
    .wdata   (host_wdata),
    .ev_set  (ev_set),
    .run_wr  (run_wr_v),
    .rdc_hit (rdc_hit_v),
    .tx_fire (tx_fire_v),
    .status  (isr_v),
    .mask    (imr_v),
    .irq     (irq)
  );

  nic_cfg_regs #(
    .END_PAGE   (END_PAGE),
    .STN_BYTES  (STN_BYTES),
    .HASH_BYTES (HASH_BYTES)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr_v),
    .idx        (idx_v),
    .wdata      (host_wdata),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .ring_bnd   (ring_bnd),
    .ring_cur   (ring_cur),
    .tpsr       (tpsr_v),
    .tcnt       (tcnt_v),
    .rdma_addr  (rdma_addr),
    .rdma_cnt   (rdma_cnt),
    .rx_cfg     (rx_cfg),
    .data_cfg   (data_cfg),
    .stn_addr   (stn_addr),
    .mc_hash    (mc_hash)
  );

  nic_read_mux #(
    .STN_BYTES  (STN_BYTES),
    .HASH_BYTES (HASH_BYTES),
    .ID_LO      (ID_LO),
    .ID_HI      (ID_HI)
  ) u_rd (
    .off        (host_addr),
    .idx        (idx_v),
    .cmd        (cmd_v),
    .status     (isr_v),
    .tsr        (tsr_v),
    .rx_stat    (rx_stat),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .ring_bnd   (ring_bnd),
    .ring_cur   (ring_cur),
    .rdma_addr  (rdma_addr),
    .stn_addr   (stn_addr),
    .mc_hash    (mc_hash),
    .rdata      (host_rdata)
  );

endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk #(
  parameter logic [7:0] END_PAGE = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [3:0]  host_addr,
  input logic [7:0]  host_wdata,
  input logic [6:0]  ev_set,
  input logic        irq,
  input logic        tx_req,
  input logic [7:0]  tx_page,
  input logic [15:0] tx_len,
  input logic [7:0]  ring_start,
  input logic [7:0]  st,
  input logic [7:0]  msk,
  input logic [7:0]  cmd,
  input logic [7:0]  tpsr,
  input logic [15:0] tcnt
);

  logic cmd_go;
  logic cmd_tx;
  assign cmd_go = host_wr && host_addr == 4'h0 && !host_wdata[0];
  assign cmd_tx = cmd_go && host_wdata[2];

  assert_tx_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  assert_tx_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx |=> (tx_req && tx_page == $past(tpsr) && tx_len == $past(tcnt)));

  assert_tx_selfclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx |=> !cmd[2]);

  assert_reset_bit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !st[7]);

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 4'h7 && cmd[7:6] == 2'b00 && ev_set == 7'h00)
    |=> ((st & $past(host_wdata) & 8'h7F) == 8'h00));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((msk & 8'h7F) != 8'h00));

  assert_start_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 4'h1 && cmd[7:6] == 2'b00 && host_wdata > END_PAGE)
    |=> $stable(ring_start));

endmodule

bind nic_regbank nic_regbank_chk #(.END_PAGE(END_PAGE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .ev_set     (ev_set),
  .irq        (irq),
  .tx_req     (tx_req),
  .tx_page    (tx_page),
  .tx_len     (tx_len),
  .ring_start (ring_start),
  .st         (isr_v),
  .msk        (imr_v),
  .cmd        (cmd_v),
  .tpsr       (tpsr_v),
  .tcnt       (tcnt_v)
);

// File: tb/nic_regbank_tb.sv
`timescale 1ns/1ps
module nic_regbank_tb;

  localparam logic [7:0] END_PG = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic [6:0]  ev_set = 7'h00;
  logic [7:0]  rx_stat = 8'hA5;
  logic        irq, tx_req;
  logic [7:0]  tx_page;
  logic [15:0] tx_len;
  logic [7:0]  ring_start, ring_stop, ring_bnd, ring_cur;
  logic [15:0] rdma_addr, rdma_cnt;
  logic [7:0]  rx_cfg, data_cfg;
  logic [47:0] stn_addr;
  logic [63:0] mc_hash;

  always #4 clk = ~clk;

  nic_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_set(ev_set),
    .rx_stat(rx_stat), .irq(irq), .tx_req(tx_req), .tx_page(tx_page),
    .tx_len(tx_len), .ring_start(ring_start), .ring_stop(ring_stop),
    .ring_bnd(ring_bnd), .ring_cur(ring_cur), .rdma_addr(rdma_addr),
    .rdma_cnt(rdma_cnt), .rx_cfg(rx_cfg), .data_cfg(data_cfg),
    .stn_addr(stn_addr), .mc_hash(mc_hash)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_cmd, m_isr, m_imr, m_tsr, m_start, m_stop, m_bnd, m_cur, m_tpsr;
  logic [7:0]  m_rxc, m_dcf, m_txp;
  logic [15:0] m_tcnt, m_rsar, m_rcnt, m_txl;
  logic [7:0]  m_stn [6];
  logic [7:0]  m_mc [8];
  logic        m_tx;
  logic [7:0]  n_isr;
  int          e;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 8'h01; m_isr = 8'h80; m_imr = 0; m_tsr = 0;
      m_start = 0; m_stop = 0; m_bnd = 0; m_cur = 0; m_tpsr = 0;
      m_rxc = 0; m_dcf = 0; m_tcnt = 0; m_rsar = 0; m_rcnt = 0;
      m_tx = 0; m_txp = 0; m_txl = 0;
      foreach (m_stn[i]) m_stn[i] = 0;
      foreach (m_mc[i]) m_mc[i] = 0;
    end else begin
      e = int'(m_cmd[7:6]) * 16 + int'(host_addr);
      n_isr = m_isr;
      m_tx = 0;
      if (host_wr && host_addr == 0) begin
        m_cmd = host_wdata;
        if (!host_wdata[0]) begin
          n_isr[7] = 0;
          if ((host_wdata[3] || host_wdata[4]) && m_rcnt == 0) n_isr[6] = 1;
          if (host_wdata[2]) begin
            m_tx = 1; m_txp = m_tpsr; m_txl = m_tcnt; m_tsr = 8'h01;
            n_isr[1] = 1; m_cmd[2] = 0;
          end
        end
      end else if (host_wr) begin
        case (e)
          1:  if (host_wdata <= END_PG) m_start = host_wdata;
          2:  if (host_wdata <= END_PG) m_stop = host_wdata;
          3:  if (host_wdata < END_PG) m_bnd = host_wdata;
          4:  m_tpsr = host_wdata;
          5:  m_tcnt[7:0] = host_wdata;
          6:  m_tcnt[15:8] = host_wdata;
          7:  n_isr = n_isr & ~(host_wdata & 8'h7F);
          8:  m_rsar[7:0] = host_wdata;
          9:  m_rsar[15:8] = host_wdata;
          10: m_rcnt[7:0] = host_wdata;
          11: m_rcnt[15:8] = host_wdata;
          12: m_rxc = host_wdata;
          14: m_dcf = host_wdata;
          15: m_imr = host_wdata;
          23: if (host_wdata < END_PG) m_cur = host_wdata;
          default: begin
            if (e >= 17 && e <= 22) m_stn[e-17] = host_wdata;
            if (e >= 24 && e <= 31) m_mc[e-24] = host_wdata;
          end
        endcase
      end
      m_isr = n_isr | {1'b0, ev_set};
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    int x;
    x = int'(m_cmd[7:6]) * 16 + int'(a);
    if (a == 0) return m_cmd;
    case (x)
      3:  return m_bnd;
      4:  return m_tsr;
      7:  return m_isr;
      8:  return m_rsar[7:0];
      9:  return m_rsar[15:8];
      10: return 8'h50;
      11: return 8'h43;
      12: return rx_stat;
      23: return m_cur;
      33: return m_start;
      34: return m_stop;
      default: begin
        if (x >= 17 && x <= 22) return m_stn[x-17];
        if (x >= 24 && x <= 31) return m_mc[x-24];
        return 8'h00;
      end
    endcase
  endfunction

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 rdata", host_rdata, m_read(host_addr));
      chk("R8 irq", irq, ((m_isr & m_imr & 8'h7F) != 0));
      chk("R11 tx_req", tx_req, m_tx);
      if (m_tx) chk("R11 tx fields", {tx_page, tx_len}, {m_txp, m_txl});
      chk("R12 ring", {ring_start, ring_stop, ring_bnd, ring_cur},
          {m_start, m_stop, m_bnd, m_cur});
      chk("R5 rdma", {rdma_addr, rdma_cnt}, {m_rsar, m_rcnt});
      chk("R4 cfg", {rx_cfg, data_cfg}, {m_rxc, m_dcf});
      chk("R4 stn", stn_addr, {m_stn[5], m_stn[4], m_stn[3], m_stn[2], m_stn[1], m_stn[0]});
      chk("R4 hash", mc_hash, {m_mc[7], m_mc[6], m_mc[5], m_mc[4],
                               m_mc[3], m_mc[2], m_mc[1], m_mc[0]});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #2;
    host_wr = 0;
  endtask

  task automatic rdx(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #2;
    host_addr = a;
    @(negedge clk); #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    rdx(4'h0, 8'h01, "R1 cmd");
    rdx(4'h7, 8'h80, "R1 status");
    chk("R1 irq", irq, 1'b0);
    chk("R1 tx_req", tx_req, 1'b0);
    chk("R1 ring", {ring_start, ring_stop, ring_bnd, ring_cur}, 32'h0);

    // R8 bit 7 never interrupts, R6 bit 7 survives a clear
    wr(4'hF, 8'h80);
    @(negedge clk); chk("R8 bit7 masked", irq, 1'b0);
    wr(4'h7, 8'hFF);
    rdx(4'h7, 8'h80, "R6 bit7 kept");

    // R9 reset bit cleared only by a started command
    wr(4'h0, 8'h21);
    rdx(4'h7, 8'h80, "R9 stop set");
    wr(4'h0, 8'h22);
    rdx(4'h7, 8'h00, "R9 stop clear");

    // R12 ring pointer limits, R4 page-0 writes
    wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'h3, 8'h4C);
    wr(4'h1, 8'h81); wr(4'h2, 8'h81); wr(4'h3, 8'h80);
    rdx(4'h3, 8'h4C, "R12 boundary at limit");
    wr(4'h3, 8'h7F);
    rdx(4'h3, 8'h7F, "R12 boundary below limit");
    wr(4'hC, 8'h1C); wr(4'hE, 8'h49);
    @(negedge clk); chk("R4 config", {rx_cfg, data_cfg}, 16'h1C49);
    wr(4'h0, 8'hA2);
    rdx(4'h1, 8'h46, "R12 start kept");
    rdx(4'h2, 8'h80, "R12 stop at limit");
    rdx(4'h3, 8'h00, "R3 page2 unmapped");

    // R2 page 1 aliasing, R4 station and hash
    wr(4'h0, 8'h62);
    for (int k = 1; k <= 6; k++) wr(4'(k), 8'(k * 17));
    wr(4'h7, 8'h47); wr(4'h7, 8'h80);
    for (int k = 8; k <= 15; k++) wr(4'(k), 8'(8 + k));
    rdx(4'h1, 8'h11, "R2 page1 offset1");
    rdx(4'h3, 8'h33, "R2 page1 offset3");
    rdx(4'h7, 8'h47, "R12 current kept");
    rdx(4'hC, 8'h14, "R3 hash byte4");
    rdx(4'h0, 8'h62, "R2 cmd on page1");
    chk("R4 station", stn_addr, 48'h665544332211);

    // R3 page 0 constants and zeros, page 3 all zero
    wr(4'h0, 8'h22);
    rdx(4'h3, 8'h7F, "R2 page0 offset3");
    rdx(4'hA, 8'h50, "R3 id low");
    rdx(4'hB, 8'h43, "R3 id high");
    rdx(4'hC, 8'hA5, "R3 rx status");
    rdx(4'hD, 8'h00, "R3 unmapped");
    wr(4'h0, 8'hE2);
    rdx(4'h1, 8'h00, "R3 page3");
    rdx(4'h7, 8'h00, "R3 page3");
    wr(4'h0, 8'h22);

    // R5 byte halves
    wr(4'h8, 8'h34); wr(4'h9, 8'h12); wr(4'h8, 8'h78);
    rdx(4'h8, 8'h78, "R5 addr low");
    rdx(4'h9, 8'h12, "R5 addr high kept");
    wr(4'hA, 8'h05); wr(4'hB, 8'h00);
    @(negedge clk); chk("R5 count", rdma_cnt, 16'h0005);

    // R10 zero-count completion
    wr(4'h0, 8'h0A);
    rdx(4'h7, 8'h00, "R10 nonzero count");
    wr(4'hA, 8'h00);
    wr(4'h0, 8'h12);
    rdx(4'h7, 8'h40, "R10 zero count");
    wr(4'h7, 8'h40);
    rdx(4'h7, 8'h00, "R6 clear bit6");

    // R7 events, R8 interrupt
    wr(4'hF, 8'h04);
    @(posedge clk); #2 ev_set = 7'h05;
    @(posedge clk); #2 ev_set = 7'h00;
    rdx(4'h7, 8'h05, "R7 event set");
    chk("R8 irq high", irq, 1'b1);
    wr(4'h7, 8'h04);
    rdx(4'h7, 8'h01, "R6 partial clear");
    chk("R8 irq low", irq, 1'b0);
    @(posedge clk); #2;
    host_wr = 1; host_addr = 4'h7; host_wdata = 8'h01; ev_set = 7'h01;
    @(posedge clk); #2;
    host_wr = 0; ev_set = 7'h00;
    rdx(4'h7, 8'h01, "R7 set beats clear");
    wr(4'h7, 8'h01);

    // R11 transmit
    wr(4'h4, 8'h40); wr(4'h5, 8'h3C); wr(4'h6, 8'h01);
    wr(4'h0, 8'h26);
    @(negedge clk);
    chk("R11 pulse", tx_req, 1'b1);
    chk("R11 fields", {tx_page, tx_len}, {8'h40, 16'h013C});
    @(negedge clk);
    chk("R11 pulse ends", tx_req, 1'b0);
    rdx(4'h0, 8'h22, "R11 self clear");
    rdx(4'h4, 8'h01, "R11 tx status");
    rdx(4'h7, 8'h02, "R11 status bit1");
    wr(4'h7, 8'h02);
    wr(4'h0, 8'h05);
    @(negedge clk);
    chk("R11 no pulse when stopped", tx_req, 1'b0);
    rdx(4'h0, 8'h05, "R11 stored as written");
    rdx(4'h7, 8'h00, "R11 no status when stopped");

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule